// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value in whole nanoseconds, 44 bits wide, clocked at 125 MHz. On every clock it adds a programmable 32-bit fixed-point rate word to a 28-bit fractional accumulator. The whole nanoseconds that fall out of that sum advance the time value. The rate word counts in units of 2^-28 ns. Its reset value of 0x80000000 advances time by exactly 8 ns per cycle, and software trims the rate in parts-per-billion steps by moving the word up or down from that value.

Software reaches the counter through a simple synchronous register bus with byte address, write strobe, write data, read strobe and registered read data. The 44-bit time is spread over three registers: a 4-bit fine field, a 32-bit middle field and an 8-bit upper field. Software loads a new time by writing the fine field, then the middle field, then the upper field, usually with the rate word at zero so the value does not move while it is being loaded. A read of the upper field freezes a copy of the middle field, so two successive reads give a 40-bit value from a single instant.

Top module: `ns_tod_counter`

## Requirements
- R1: After reset the time and the fraction are zero and the rate register reads 0x80000000, so time starts at 0 and advances from the first clock after reset.
- R2: Each clock without a time-field write adds the rate word to the fraction; the carry above bit 27 is added to the time, so the reset rate advances time by exactly 8 ns per clock.
- R3: While the rate register holds zero and no time field is written, the time does not change.
- R4: Register map by byte offset (address bits [3:2]): 0x00 fine field = time[3:0] in data[3:0]; 0x04 middle field = time[35:4]; 0x08 upper field = time[43:36] in data[7:0]; 0x0C rate word. Unused read bits are zero. Read data appears on the clock edge that samples the read strobe.
- R5: A write to offset 0x08 loads time[43:36] from write data bits [15:8]; data bits [7:0] and [31:16] have no effect.
- R6: Time is kept modulo 2^44: an advance past 2^44-1 continues from zero.
- R7: A write to the fine field clears the fraction, so a loaded time starts on a whole nanosecond.
- R8: In a clock with a write to any time field, no rate step is applied; fields not written keep their values.
- R9: A read of offset 0x08 copies the middle field into a shadow; the next read of offset 0x04 returns that copy once, and later reads of 0x04 return the live field.
- R10: Starting from a zero fraction, k clocks at rate word W advance time by floor(k*W/2^28), for trimmed words up to +/-50,000,000 ppb, where the trim offset is round(|ppb|*2^28/125e6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, registered |

## Verification
The assertions assume the bus never issues a read and a write to the same register in one clock. They also assume the rate word is an exact multiple of a nanosecond whenever the default-rate property is meant to apply. The bench drives each access alone, on its own clock, from the falling edge. Every time-dependent check first sets the rate to zero and loads a known time, so the expected values follow only from the number of clocks the bench counts between its writes.

// File: rtl/tod_pkg.sv
package tod_pkg;

  // register select taken from the word part of the byte address
  typedef enum logic [1:0] {
    SEL_FINE  = 2'd0,
    SEL_MID   = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_RATE  = 2'd3
  } tod_sel_e;

  // write strobes, one per register
  typedef struct packed {
    logic rate;
    logic upper;
    logic mid;
    logic fine;
  } tod_wr_t;

endpackage

// File: rtl/tod_rate_accum.sv
module tod_rate_accum #(
  parameter int unsigned FRAC_W = 28,
  parameter int unsigned INC_W  = 32,
  parameter int unsigned STEP_W = INC_W + 1 - FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  rate_word,
  input  logic              hold,
  input  logic              frac_clr,
  output logic [STEP_W-1:0] ns_step,
  output logic [FRAC_W-1:0] frac_q
);

  localparam int unsigned SUM_W = INC_W + 1;

  logic [SUM_W-1:0] sum;

  function automatic logic [SUM_W-1:0] accum_sum(input logic [FRAC_W-1:0] f,
                                                 input logic [INC_W-1:0]  w);
    return {1'b0, w} + {{(SUM_W - FRAC_W){1'b0}}, f};
  endfunction

  assign sum     = accum_sum(frac_q, rate_word);
  assign ns_step = hold ? '0 : sum[SUM_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_q <= '0;
    end else if (frac_clr) begin
      frac_q <= '0;
    end else if (!hold) begin
      frac_q <= sum[FRAC_W-1:0];
    end
  end

  // R7: a fine-field write leaves a whole nanosecond
  p_frac_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frac_clr |=> (frac_q == '0));

endmodule

// File: rtl/tod_time_core.sv
module tod_time_core import tod_pkg::*; #(
  parameter int unsigned LOW_W  = 4,
  parameter int unsigned MID_W  = 32,
  parameter int unsigned TOP_W  = 8,
  parameter int unsigned STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tod_wr_t           wr,
  input  logic [LOW_W-1:0]  ld_fine,
  input  logic [MID_W-1:0]  ld_mid,
  input  logic [TOP_W-1:0]  ld_upper,
  input  logic [STEP_W-1:0] ns_step,
  output logic [LOW_W-1:0]  fine_q,
  output logic [MID_W-1:0]  mid_q,
  output logic [TOP_W-1:0]  upper_q
);

  localparam int unsigned TIME_W = LOW_W + MID_W + TOP_W;

  logic              time_wr;
  logic [TIME_W-1:0] now;
  logic [TIME_W-1:0] nxt;

  function automatic logic [TIME_W-1:0] advance(input logic [TIME_W-1:0] t,
                                                input logic [STEP_W-1:0] s);
    return t + {{(TIME_W - STEP_W){1'b0}}, s};
  endfunction

  assign time_wr = wr.fine | wr.mid | wr.upper;
  assign now     = {upper_q, mid_q, fine_q};
  assign nxt     = advance(now, ns_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fine_q  <= '0;
      mid_q   <= '0;
      upper_q <= '0;
    end else if (time_wr) begin
      if (wr.fine)  fine_q  <= ld_fine;
      if (wr.mid)   mid_q   <= ld_mid;
      if (wr.upper) upper_q <= ld_upper;
    end else begin
      {upper_q, mid_q, fine_q} <= nxt;
    end
  end

  // R8: a middle-field write holds the other fields for that clock
  p_write_blocks_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.mid && !wr.fine && !wr.upper) |=>
      (fine_q == $past(fine_q)) && (upper_q == $past(upper_q)));

endmodule

// File: rtl/tod_reg_if.sv
module tod_reg_if import tod_pkg::*; #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LOW_W      = 4,
  parameter int unsigned MID_W      = 32,
  parameter int unsigned TOP_W      = 8,
  parameter int unsigned INC_W      = 32,
  parameter int unsigned TOP_WR_LSB = 8,
  parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [LOW_W-1:0]  fine_q,
  input  logic [MID_W-1:0]  mid_q,
  input  logic [TOP_W-1:0]  upper_q,
  output tod_wr_t           wr,
  output logic [LOW_W-1:0]  ld_fine,
  output logic [MID_W-1:0]  ld_mid,
  output logic [TOP_W-1:0]  ld_upper,
  output logic [INC_W-1:0]  rate_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned SEL_LSB = 2;
  localparam int unsigned SEL_W   = 2;

  tod_sel_e         sel;
  logic [MID_W-1:0] shadow_q;
  logic             shadow_vld;
  logic             rd_upper;
  logic             rd_mid;
  logic             unused_bits;

  assign sel         = tod_sel_e'(addr[SEL_LSB +: SEL_W]);
  assign unused_bits = ^{addr[SEL_LSB-1:0], wdata};
  assign rd_upper    = rd_en && (sel == SEL_UPPER);
  assign rd_mid      = rd_en && (sel == SEL_MID);

  function automatic tod_wr_t decode_wr(input logic en, input tod_sel_e s);
    tod_wr_t w;
    w = '0;
    if (en) begin
      case (s)
        SEL_FINE:  w.fine  = 1'b1;
        SEL_MID:   w.mid   = 1'b1;
        SEL_UPPER: w.upper = 1'b1;
        default:   w.rate  = 1'b1;
      endcase
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] read_mux(input tod_sel_e         s,
                                                 input logic [LOW_W-1:0] f,
                                                 input logic [MID_W-1:0] m,
                                                 input logic [TOP_W-1:0] u,
                                                 input logic [INC_W-1:0] r,
                                                 input logic [MID_W-1:0] sh,
                                                 input logic             shv);
    logic [DATA_W-1:0] d;
    d = '0;
    case (s)
      SEL_FINE:  d[LOW_W-1:0] = f;
      SEL_MID:   d[MID_W-1:0] = shv ? sh : m;
      SEL_UPPER: d[TOP_W-1:0] = u;
      default:   d[INC_W-1:0] = r;
    endcase
    return d;
  endfunction

  assign wr       = decode_wr(wr_en, sel);
  assign ld_fine  = wdata[LOW_W-1:0];
  assign ld_mid   = wdata[MID_W-1:0];
  assign ld_upper = wdata[TOP_WR_LSB +: TOP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= INC_RESET;
    end else if (wr.rate) begin
      rate_q <= wdata[INC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q   <= '0;
      shadow_vld <= 1'b0;
    end else if (rd_upper) begin
      shadow_q   <= mid_q;
      shadow_vld <= 1'b1;
    end else if (rd_mid) begin
      shadow_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= read_mux(sel, fine_q, mid_q, upper_q, rate_q, shadow_q, shadow_vld);
    end
  end

  // R9: an upper read arms the shadow
  p_shadow_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_upper |=> shadow_vld);

  // R9: a middle read right after an upper read returns the value frozen then
  p_shadow_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mid && $past(rd_upper)) |=> (rdata[MID_W-1:0] == $past(mid_q, 2)));

endmodule

// File: rtl/ns_tod_counter.sv
module ns_tod_counter import tod_pkg::*; #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LOW_W      = 4,
  parameter int unsigned MID_W      = 32,
  parameter int unsigned TOP_W      = 8,
  parameter int unsigned FRAC_W     = 28,
  parameter int unsigned INC_W      = 32,
  parameter int unsigned TOP_WR_LSB = 8,
  parameter logic [INC_W-1:0] INC_RESET = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int unsigned TIME_W = LOW_W + MID_W + TOP_W;
  localparam int unsigned STEP_W = INC_W + 1 - FRAC_W;
  localparam logic [TIME_W-1:0] RESET_STEP = TIME_W'(INC_RESET >> FRAC_W);

  tod_wr_t           wr;
  logic [LOW_W-1:0]  ld_fine;
  logic [MID_W-1:0]  ld_mid;
  logic [TOP_W-1:0]  ld_upper;
  logic [INC_W-1:0]  rate_q;
  logic [STEP_W-1:0] ns_step;
  logic [FRAC_W-1:0] frac_q;
  logic [LOW_W-1:0]  fine_q;
  logic [MID_W-1:0]  mid_q;
  logic [TOP_W-1:0]  upper_q;
  logic              time_wr;
  logic [TIME_W-1:0] time_q;

  assign time_wr = wr.fine | wr.mid | wr.upper;
  assign time_q  = {upper_q, mid_q, fine_q};

  tod_reg_if #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_W(LOW_W), .MID_W(MID_W),
    .TOP_W(TOP_W), .INC_W(INC_W), .TOP_WR_LSB(TOP_WR_LSB), .INC_RESET(INC_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr),
    .wdata(reg_wdata), .rd_en(reg_rd), .fine_q(fine_q), .mid_q(mid_q),
    .upper_q(upper_q), .wr(wr), .ld_fine(ld_fine), .ld_mid(ld_mid),
    .ld_upper(ld_upper), .rate_q(rate_q), .rdata(reg_rdata)
  );

  tod_rate_accum #(
    .FRAC_W(FRAC_W), .INC_W(INC_W), .STEP_W(STEP_W)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .rate_word(rate_q), .hold(time_wr),
    .frac_clr(wr.fine), .ns_step(ns_step), .frac_q(frac_q)
  );

  tod_time_core #(
    .LOW_W(LOW_W), .MID_W(MID_W), .TOP_W(TOP_W), .STEP_W(STEP_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ld_fine(ld_fine), .ld_mid(ld_mid),
    .ld_upper(ld_upper), .ns_step(ns_step), .fine_q(fine_q), .mid_q(mid_q),
    .upper_q(upper_q)
  );

  // R3: zero rate freezes time
  p_zero_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0 && !time_wr) |=> $stable(time_q));

  // R2: reset rate from a whole nanosecond gives a fixed step
  p_default_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == INC_RESET && frac_q == '0 && wr == '0) |=>
      (time_q == $past(time_q) + RESET_STEP));

  // R5: upper field is loaded from the shifted byte of the write data
  p_upper_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && tod_sel_e'(reg_addr[3:2]) == SEL_UPPER) |=>
      (upper_q == $past(reg_wdata[TOP_WR_LSB +: TOP_W])));

endmodule

// File: tb/ns_tod_counter_tb_top.sv
`timescale 1ns/1ps
module ns_tod_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  localparam logic [3:0] A_FINE = 4'h0, A_MID = 4'h4, A_UPPER = 4'h8, A_RATE = 4'hC;
  localparam logic [63:0] NOMINAL = 64'h8000_0000;
  localparam logic [63:0] MOD44 = 64'h0000_1000_0000_0000;

  always #2 clk = ~clk;

  ns_tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // every bus task starts and ends at a falling edge; one access per clock
  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic rd_time(output logic [63:0] t);
    logic [31:0] u, m, f;
    rd_reg(A_UPPER, u);
    rd_reg(A_MID, m);
    rd_reg(A_FINE, f);
    t = ({56'd0, u[7:0]} << 36) | ({32'd0, m} << 4) | {60'd0, f[3:0]};
  endtask

  task automatic freeze_load(input logic [63:0] t);
    wr_reg(A_RATE, 32'h0);
    wr_reg(A_FINE, {28'd0, t[3:0]});
    wr_reg(A_MID, t[35:4]);
    wr_reg(A_UPPER, {16'd0, t[43:36], 8'h00});
  endtask

  // k clocks at rate w, then frozen again
  task automatic run_rate(input logic [31:0] w, input int k);
    wr_reg(A_RATE, w);
    repeat (k - 1) @(negedge clk);
    wr_reg(A_RATE, 32'h0);
  endtask

  function automatic logic [63:0] trim_word(input logic [63:0] ppb, input bit neg);
    logic [63:0] delta;
    delta = (ppb * 64'd268435456 + 64'd62500000) / 64'd125000000;
    return neg ? NOMINAL - delta : NOMINAL + delta;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    logic [63:0] t;
    rd_reg(A_RATE, d);
    check("R1 rate reset value", {32'd0, d}, NOMINAL);
    rd_reg(A_UPPER, d);
    check("R1 upper field after reset", {32'd0, d}, 64'd0);
    wr_reg(A_RATE, 32'h0);
    rd_time(t);
    check("R1/R2 time after three clocks from reset", t, 64'd24);
  endtask

  task automatic t_default_rate();
    logic [63:0] t;
    freeze_load(64'd0);
    run_rate(NOMINAL[31:0], 100);
    rd_time(t);
    check("R2 nominal rate 100 clocks", t, 64'd800);
  endtask

  task automatic t_zero_hold();
    logic [63:0] t;
    freeze_load(64'h123_4567_89AB);
    repeat (50) @(negedge clk);
    rd_time(t);
    check("R3 zero rate holds time", t, 64'h123_4567_89AB);
  endtask

  task automatic t_field_map();
    logic [31:0] d;
    freeze_load(64'hA5C_3C3C_3C37);
    rd_reg(A_FINE, d);
    check("R4 fine field", {32'd0, d}, 64'h7);
    rd_reg(A_MID, d);
    check("R4 middle field", {32'd0, d}, 64'hC3C3_C3C3);
    rd_reg(A_UPPER, d);
    check("R4 upper field", {32'd0, d}, 64'hA5);
    rd_reg(A_MID, d);
    wr_reg(A_RATE, 32'h1234_5678);
    rd_reg(A_RATE, d);
    check("R4 rate readback", {32'd0, d}, 64'h1234_5678);
    wr_reg(A_RATE, 32'h0);
  endtask

  task automatic t_upper_write();
    logic [31:0] d;
    logic [63:0] t;
    freeze_load(64'h011_1111_1112);
    wr_reg(A_UPPER, 32'hFFFF_5AFF);
    rd_reg(A_UPPER, d);
    check("R5 upper loaded from bits 15:8", {32'd0, d}, 64'h5A);
    rd_time(t);
    check("R5 other bits ignored", t, 64'h5A1_1111_1112);
  endtask

  task automatic t_wrap();
    logic [63:0] t;
    freeze_load(MOD44 - 64'd4);
    run_rate(NOMINAL[31:0], 2);
    rd_time(t);
    check("R6 wrap modulo 2^44", t, 64'd12);
  endtask

  task automatic t_frac_clear();
    logic [63:0] t;
    freeze_load(64'd0);
    run_rate(32'h1800_0000, 3);
    rd_time(t);
    check("R7 fractional accumulation 3 x 1.5 ns", t, 64'd4);
    wr_reg(A_FINE, 32'h0);
    run_rate(32'h1800_0000, 1);
    rd_time(t);
    check("R7 fine write clears fraction", t, 64'd1);
  endtask

  task automatic t_priority();
    logic [63:0] t;
    freeze_load(64'd0);
    wr_reg(A_RATE, NOMINAL[31:0]);
    wr_reg(A_FINE, 32'h3);
    wr_reg(A_RATE, 32'h0);
    rd_time(t);
    check("R8 write clock applies no step", t, 64'd11);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    freeze_load(64'h01F_FFFF_FFF0);
    rd_reg(A_UPPER, d);
    check("R9 upper before advance", {32'd0, d}, 64'h1);
    run_rate(NOMINAL[31:0], 10);
    rd_reg(A_MID, d);
    check("R9 middle returns frozen copy", {32'd0, d}, 64'hFFFF_FFFF);
    rd_reg(A_MID, d);
    check("R9 later middle read is live", {32'd0, d}, 64'h4);
    rd_reg(A_UPPER, d);
    check("R9 upper after carry", {32'd0, d}, 64'h2);
  endtask

  task automatic t_trim(input logic [63:0] ppb, input bit neg);
    logic [63:0] t, w;
    w = trim_word(ppb, neg);
    freeze_load(64'd0);
    run_rate(w[31:0], 1000);
    rd_time(t);
    check("R10 trimmed rate over 1000 clocks", t, (64'd1000 * w) >> 28);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_rate();
    t_zero_hold();
    t_field_map();
    t_upper_write();
    t_wrap();
    t_frac_clear();
    t_priority();
    t_snapshot();
    t_trim(64'd50_000_000, 1'b0);
    t_trim(64'd50_000_000, 1'b1);
    t_trim(64'd100, 1'b0);
    t_trim(64'd123_456, 1'b1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule